// File: doc/BRIEF.md
# Tolerant Sign-Compression Line Encoder

The encoder receives one cache line, on a miss fill or on a store, and decides in which form the line goes into a split data array. Each word is cut into a lower half and an upper half. An upper half that is all zeros or all ones collapses to one sign bit. The lower half is always kept as it is.

A small, fixed number of words whose upper halves do not collapse is still accepted. Their upper halves are copied into dedicated overflow slots, and a per-word position flag marks each such word. If more words fail than there are slots, the line is kept uncompressed and its full upper halves are presented for the second half of the array.

The logic is combinational and ends in a single output register. The class of each line (fully compressed, compressed with overflow, or raw) is reported with the data.

Top module: `sign_line_enc`

## Requirements
- R1: `valid_o` is high in the cycle after an edge at which `valid_i` was high, and low after an edge at which `valid_i` was low.
- R2: A word's upper half fits only when all its bits are 0 or all are 1. Its sign bit in `sign_o` is 1 for all ones and 0 for all zeros. Words that do not fit, and all words of a raw line, show sign 0.
- R3: For every accepted line, `lower_o[w*HALF_W +: HALF_W]` equals the lower half of word w, unchanged.
- R4: When the number of words that do not fit is at most `N_SLOTS`, `packed_o` is 1. Bit w of `slot_pos_o` is set exactly for each such word w. Slot k (`slot_o[k*HALF_W +: HALF_W]`) holds the upper half of the k-th such word, counted in ascending word index. Unused slots are zero.
- R5: When more than `N_SLOTS` words do not fit, `packed_o` is 0, and `slot_pos_o`, `slot_o` and `sign_o` are all zero.
- R6: `upper_o[w*HALF_W +: HALF_W]` holds the upper half of word w when the line is raw, and is zero when the line is packed.
- R7: `class_o` is 0 when every word fits, 1 when the line is packed with at least one overflow word, and 2 when the line is raw.
- R8: No more than `N_SLOTS` position flags are ever set.
- R9: While `valid_i` is low, every data output keeps its value, whatever `line_i` carries.
- R10: While `rst_ni` is low, every output is zero. Reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Line on `line_i` is to be encoded |
| line_i | input | N_WORDS*WORD_W | Input line, word 0 in the lowest bits |
| valid_o | output | 1 | Encoded result valid |
| packed_o | output | 1 | Line is stored in compressed form |
| class_o | output | 2 | 0 all fit, 1 packed with overflow, 2 raw |
| sign_o | output | N_WORDS | Per-word sign bit |
| lower_o | output | N_WORDS*HALF_W | Lower halves of all words |
| slot_o | output | max(N_SLOTS,1)*HALF_W | Overflow slots |
| slot_pos_o | output | N_WORDS | Words whose upper half sits in a slot |
| upper_o | output | N_WORDS*HALF_W | Full upper halves for a raw line |

## Verification
Every result is due exactly one rising edge after the edge that sampled `valid_i` high, because one register lies between input and output. The bench drives inputs on the falling edge and reads all outputs at the next falling edge, which falls half a period after the result register loads. The hold requirement is checked the same way. A different line is applied with `valid_i` low, and the outputs are read one falling edge later. Reset values are read while reset is held, both before the first edge and during a reset raised in the middle of the run.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_SPILL = 2'd1,
    CLS_RAW   = 2'd2
  } line_cls_e;
endpackage

// File: rtl/sce_half_detect.sv
module sce_half_detect #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] upper_i,
  output logic              fit_o,
  output logic              sign_o
);
  logic all_one, all_zero;
  assign all_one  = &upper_i;
  assign all_zero = ~|upper_i;
  assign fit_o    = all_one | all_zero;
  assign sign_o   = all_one;
endmodule

// File: rtl/sce_slot_pack.sv
module sce_slot_pack #(
  parameter int N_WORDS    = 8,
  parameter int HALF_W     = 16,
  parameter int N_SLOTS    = 2,
  parameter int SLOT_STORE = 2
) (
  input  logic [N_WORDS*HALF_W-1:0]    upper_i,
  input  logic [N_WORDS-1:0]           fit_i,
  output logic [SLOT_STORE*HALF_W-1:0] slot_o,
  output logic [N_WORDS-1:0]           pos_o,
  output logic                         over_o,
  output logic                         spill_o
);
  logic [SLOT_STORE*HALF_W-1:0] slot_raw;
  logic [N_WORDS-1:0]           pos_raw;
  int                           miss_cnt;

  // ascending word order fills ascending slots
  always_comb begin
    slot_raw = '0;
    pos_raw  = '0;
    miss_cnt = 0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (!fit_i[w]) begin
        if (miss_cnt < N_SLOTS) begin
          slot_raw[miss_cnt*HALF_W +: HALF_W] = upper_i[w*HALF_W +: HALF_W];
          pos_raw[w] = 1'b1;
        end
        miss_cnt = miss_cnt + 1;
      end
    end
  end

  assign over_o  = (miss_cnt > N_SLOTS);
  assign spill_o = (miss_cnt != 0);
  assign slot_o  = over_o ? '0 : slot_raw;
  assign pos_o   = over_o ? '0 : pos_raw;
endmodule

// File: rtl/sce_out_stage.sv
module sce_out_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/sign_line_enc.sv
module sign_line_enc
  import sce_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int N_WORDS    = 8,
  parameter int N_SLOTS    = 2,
  parameter int HALF_W     = WORD_W / 2,
  parameter int SLOT_STORE = (N_SLOTS == 0) ? 1 : N_SLOTS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [N_WORDS*WORD_W-1:0]    line_i,
  output logic                         valid_o,
  output logic                         packed_o,
  output logic [1:0]                   class_o,
  output logic [N_WORDS-1:0]           sign_o,
  output logic [N_WORDS*HALF_W-1:0]    lower_o,
  output logic [SLOT_STORE*HALF_W-1:0] slot_o,
  output logic [N_WORDS-1:0]           slot_pos_o,
  output logic [N_WORDS*HALF_W-1:0]    upper_o
);
  localparam int HV_W   = N_WORDS * HALF_W;
  localparam int SL_W   = SLOT_STORE * HALF_W;
  localparam int DATA_W = 1 + 2 + N_WORDS + HV_W + SL_W + N_WORDS + HV_W;

  if (N_SLOTS < 0 || N_SLOTS > N_WORDS || (WORD_W % 2) != 0) begin : g_bad_cfg
    $error("sign_line_enc: N_SLOTS must be 0..N_WORDS and WORD_W even");
  end

  logic [HV_W-1:0]    upper_w, lower_w;
  logic [N_WORDS-1:0] fit_w, sgn_w;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign lower_w[w*HALF_W +: HALF_W] = line_i[w*WORD_W +: HALF_W];
    assign upper_w[w*HALF_W +: HALF_W] = line_i[w*WORD_W+HALF_W +: HALF_W];
    sce_half_detect #(.HALF_W(HALF_W)) u_det (
      .upper_i (upper_w[w*HALF_W +: HALF_W]),
      .fit_o   (fit_w[w]),
      .sign_o  (sgn_w[w])
    );
  end

  logic [SL_W-1:0]    slot_c;
  logic [N_WORDS-1:0] pos_c;
  logic               over_c, spill_c;

  sce_slot_pack #(
    .N_WORDS(N_WORDS), .HALF_W(HALF_W), .N_SLOTS(N_SLOTS), .SLOT_STORE(SLOT_STORE)
  ) u_pack (
    .upper_i (upper_w),
    .fit_i   (fit_w),
    .slot_o  (slot_c),
    .pos_o   (pos_c),
    .over_o  (over_c),
    .spill_o (spill_c)
  );

  logic               packed_c;
  line_cls_e          cls_c;
  logic [N_WORDS-1:0] sign_c;
  logic [HV_W-1:0]    upper_c;

  always_comb begin
    packed_c = !over_c;
    sign_c   = packed_c ? sgn_w : '0;
    upper_c  = packed_c ? '0 : upper_w;
    if (over_c)       cls_c = CLS_RAW;
    else if (spill_c) cls_c = CLS_SPILL;
    else              cls_c = CLS_PLAIN;
  end

  logic [DATA_W-1:0] d_bus, q_bus;
  assign d_bus = {packed_c, cls_c, sign_c, lower_w, slot_c, pos_c, upper_c};

  sce_out_stage #(.W(DATA_W)) u_data (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (valid_i), .d_i (d_bus), .q_o (q_bus)
  );
  sce_out_stage #(.W(1)) u_vld (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (1'b1), .d_i (valid_i), .q_o (valid_o)
  );

  assign {packed_o, class_o, sign_o, lower_o, slot_o, slot_pos_o, upper_o} = q_bus;
endmodule

// File: rtl/sce_check.sv
module sce_check #(
  parameter int WORD_W     = 32,
  parameter int N_WORDS    = 8,
  parameter int N_SLOTS    = 2,
  parameter int HALF_W     = 16,
  parameter int SLOT_STORE = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         valid_i,
  input logic [N_WORDS*WORD_W-1:0]    line_i,
  input logic                         valid_o,
  input logic                         packed_o,
  input logic [1:0]                   class_o,
  input logic [N_WORDS-1:0]           sign_o,
  input logic [N_WORDS*HALF_W-1:0]    lower_o,
  input logic [SLOT_STORE*HALF_W-1:0] slot_o,
  input logic [N_WORDS-1:0]           slot_pos_o,
  input logic [N_WORDS*HALF_W-1:0]    upper_o
);
  logic [N_WORDS*HALF_W-1:0] lower_in;
  for (genvar w = 0; w < N_WORDS; w++) begin : g_lo
    assign lower_in[w*HALF_W +: HALF_W] = line_i[w*WORD_W +: HALF_W];
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_sign_pos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sign_o & slot_pos_o) == '0);
  p_lower_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> lower_o == $past(lower_in));
  p_raw_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !packed_o |-> (slot_pos_o == '0 && sign_o == '0 && slot_o == '0));
  p_pk_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    packed_o |-> upper_o == '0);
  p_cls_raw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((class_o == 2'd2) == !packed_o));
  p_cls_plain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 2'd0) |-> slot_pos_o == '0);
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_pos_o) <= N_SLOTS);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(lower_o) && $stable(slot_o) && $stable(upper_o) && $stable(sign_o)));
endmodule

bind sign_line_enc sce_check #(
  .WORD_W(WORD_W), .N_WORDS(N_WORDS), .N_SLOTS(N_SLOTS),
  .HALF_W(HALF_W), .SLOT_STORE(SLOT_STORE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .line_i(line_i),
  .valid_o(valid_o), .packed_o(packed_o), .class_o(class_o), .sign_o(sign_o),
  .lower_o(lower_o), .slot_o(slot_o), .slot_pos_o(slot_pos_o), .upper_o(upper_o)
);

// File: tb/sim_sign_line_enc.sv
module sim_sign_line_enc;
  localparam int NW = 8;
  localparam int HW = 16;
  localparam int NS = 2;
  localparam int NV = 8;

  typedef struct packed {
    logic [127:0] up;
    logic         pk;
    logic [7:0]   pos;
    logic [7:0]   sg;
    logic [1:0]   cls;
  } vec_t;

  // upper halves listed word7..word0
  localparam vec_t TBL [NV] = '{
    '{128'h0000_0000_0000_0000_0000_0000_0000_0000, 1'b1, 8'h00, 8'h00, 2'd0},
    '{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1, 8'h00, 8'hFF, 2'd0},
    '{128'h0000_0000_0000_0000_0000_1234_0000_FFFF, 1'b1, 8'h04, 8'h01, 2'd1},
    '{128'h0000_ABCD_0000_FFFF_0000_FFFF_5555_FFFF, 1'b1, 8'h42, 8'h15, 2'd1},
    '{128'h00FF_0000_0000_0000_8000_0000_0000_0001, 1'b0, 8'h00, 8'h00, 2'd2},
    '{128'h1357_1357_1357_1357_1357_1357_1357_1357, 1'b0, 8'h00, 8'h00, 2'd2},
    '{128'h0000_0000_0000_0000_0000_0000_8000_7FFF, 1'b1, 8'h03, 8'h00, 2'd1},
    '{128'hFFFF_FFFF_FFFF_FFFE_FFFF_FFFF_FFFF_FFFF, 1'b1, 8'h10, 8'hEF, 2'd1}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [255:0]    line_i = '0;
  logic            valid_o, packed_o;
  logic [1:0]      class_o;
  logic [7:0]      sign_o, slot_pos_o;
  logic [127:0]    lower_o, upper_o;
  logic [31:0]     slot_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sign_line_enc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .line_i(line_i),
    .valid_o(valid_o), .packed_o(packed_o), .class_o(class_o), .sign_o(sign_o),
    .lower_o(lower_o), .slot_o(slot_o), .slot_pos_o(slot_pos_o), .upper_o(upper_o)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_lower(input int v);
    logic [127:0] r;
    for (int w = 0; w < NW; w++) r[w*HW +: HW] = 16'hA000 + 16'(v*16 + w);
    return r;
  endfunction

  function automatic logic [255:0] mk_line(input logic [127:0] up, input int v);
    logic [255:0] r;
    logic [127:0] lo;
    lo = mk_lower(v);
    for (int w = 0; w < NW; w++) r[w*32 +: 32] = {up[w*HW +: HW], lo[w*HW +: HW]};
    return r;
  endfunction

  function automatic logic [31:0] exp_slots(input logic [127:0] up, input logic [7:0] pos);
    logic [31:0] s;
    int k;
    s = '0;
    k = 0;
    for (int w = 0; w < NW; w++) begin
      if (pos[w]) begin
        s[k*HW +: HW] = up[w*HW +: HW];
        k++;
      end
    end
    return s;
  endfunction

  task automatic check_zero(input string tag);
    chk({tag, " R10 valid_o"}, 256'(valid_o), 256'd0);
    chk({tag, " R10 data"}, 256'({packed_o, class_o, sign_o, slot_pos_o, slot_o}), 256'd0);
    chk({tag, " R10 halves"}, {lower_o, upper_o}, 256'd0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #2;
    check_zero("reset");
    repeat (2) @(negedge clk);
    check_zero("reset held");
    rst_ni = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      valid_i = 1'b1;
      line_i  = mk_line(TBL[v].up, v);
      @(negedge clk);
      valid_i = 1'b0;
      chk($sformatf("R1 vec%0d valid_o", v), 256'(valid_o), 256'd1);
      chk($sformatf("R4 R5 vec%0d packed_o", v), 256'(packed_o), 256'(TBL[v].pk));
      chk($sformatf("R2 vec%0d sign_o", v), 256'(sign_o), 256'(TBL[v].sg));
      chk($sformatf("R3 vec%0d lower_o", v), 256'(lower_o), 256'(mk_lower(v)));
      chk($sformatf("R4 vec%0d slot_pos_o", v), 256'(slot_pos_o), 256'(TBL[v].pos));
      chk($sformatf("R4 vec%0d slot_o", v), 256'(slot_o), 256'(exp_slots(TBL[v].up, TBL[v].pos)));
      chk($sformatf("R6 vec%0d upper_o", v), 256'(upper_o), 256'(TBL[v].pk ? 128'd0 : TBL[v].up));
      chk($sformatf("R7 vec%0d class_o", v), 256'(class_o), 256'(TBL[v].cls));
      chk($sformatf("R8 vec%0d flag count", v), 256'($countones(slot_pos_o) <= NS), 256'd1);
    end

    // R1: valid_o falls one edge after valid_i low
    @(negedge clk);
    chk("R1 valid_o low", 256'(valid_o), 256'd0);

    // R9: new line with valid_i low leaves outputs untouched (last vector held)
    line_i = mk_line(TBL[5].up, 5);
    @(negedge clk);
    @(negedge clk);
    chk("R9 lower held", 256'(lower_o), 256'(mk_lower(7)));
    chk("R9 sign held", 256'(sign_o), 256'(TBL[7].sg));
    chk("R9 pos held", 256'(slot_pos_o), 256'(TBL[7].pos));
    chk("R9 packed held", 256'(packed_o), 256'd1);
    chk("R9 upper held", 256'(upper_o), 256'd0);

    // R4 boundary: exactly N_SLOTS misses at the last two words
    valid_i = 1'b1;
    line_i  = mk_line(128'h7000_0007_0000_0000_0000_0000_0000_0000, 9);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R4 top words pos", 256'(slot_pos_o), 256'h0C0);
    chk("R4 top words slots", 256'(slot_o), 256'h7000_0007);
    chk("R7 top words class", 256'(class_o), 256'd1);

    // R5 boundary: N_SLOTS+1 misses
    valid_i = 1'b1;
    line_i  = mk_line(128'h7000_0007_0000_0000_0000_0000_0000_0100, 10);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R5 one over packed", 256'(packed_o), 256'd0);
    chk("R5 one over slots", 256'({slot_o, slot_pos_o, sign_o}), 256'd0);
    chk("R6 one over upper", 256'(upper_o), 256'(128'h7000_0007_0000_0000_0000_0000_0000_0100));
    chk("R7 one over class", 256'(class_o), 256'd2);

    // R10: asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1;
    check_zero("mid reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule